// File: doc/BRIEF.md
# Time-over-threshold hit capture

This block turns the digital outputs of charge-to-time converters into hit records. Each input channel drives three level lines, one per gain range. A line stays high for a time that grows linearly with the charge in that range. The block watches the lines of every channel and reads a free-running timestamp from a shared time-to-digital counter. From these it records when a pulse starts, which is the photomultiplier arrival time, and when each gain line drops. It then reports one record per pulse: the channel, the chosen gain range, the arrival time, and the pulse width as the charge measure.

For each channel the block keeps the result from the most sensitive gain that is not saturated. After every accepted pulse it imposes a fixed dead window that matches the converter's recovery time, and it rejects new pulses while that window is open. It also rejects a new pulse while the channel's previous record is still waiting at the output. Rejected pulses are counted in a saturating loss counter. Records from all channels share one output that uses a valid/ready handshake and round-robin arbitration.

Top module: `tot_hit_capture`

## Requirements
- R1: A hit opens on a cycle in which a channel's three lines go from all low to at least one high, provided the channel is accepting. The time field is the `tdc_time` value sampled in that same cycle.
- R2: For each gain, width is the timestamp at that line's last falling edge minus the start time, taken modulo 2^32. A result above 65535 is clamped to 65535. A line that never went high during the hit has width 0.
- R3: A record is produced once all three lines of the channel are low again. Each record leaves the block exactly once. The bit layout is channel at [51:50], range at [49:48], time at [47:16] and width at [15:0].
- R4: The range code is the lowest line index whose line went high and whose width is strictly below `sat_limit`. Line 0 is gain ×49 (code 0), line 1 is ×7 (code 1) and line 2 is ×1 (code 2). If no line qualifies, the record carries code 2 and the width of line 2.
- R5: After a hit is accepted in cycle t, a new start detected in cycles t+1 to t+35 is rejected, and that pulse yields no record. A start in cycle t+36 or later is accepted.
- R6: A start on a channel whose previous record has not yet been taken at the output is rejected.
- R7: `loss_cnt` rises by the number of starts rejected in a cycle and stops at its all-ones value.
- R8: While `hit_valid` is high and `hit_ready` is low, `hit_valid` stays high and `hit_rec` does not change.
- R9: After reset, `hit_valid` is low and `loss_cnt` is zero.
- R10: Channels work independently. A dead window or a waiting record on one channel does not block starts on another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one cycle is one dead-time count |
| rst_n | input | 1 | Active-low synchronous reset |
| qtc_lvl | input | 9 | Converter lines; bit 3*ch+g is gain line g of channel ch |
| tdc_time | input | 32 | Shared timestamp, in TDC LSBs |
| sat_limit | input | 16 | Width at or above which a gain counts as saturated |
| hit_ready | input | 1 | Downstream accepts the record |
| hit_valid | output | 1 | A record is presented |
| hit_rec | output | 52 | Hit record {channel, range, time, width} |
| loss_cnt | output | 8 | Saturating count of rejected pulses |

## Verification
The assertions assume that the converter lines and the timestamp are synchronous to `clk`. They also assume that reset is applied before any pulse arrives. The stimulus changes lines, timestamp and `hit_ready` only on the falling clock edge, so every sampled value is settled before the rising edge. Test pulses put each gain line high in the same cycle. Some pulses leave the most sensitive line silent, and rejected starts are placed at exact offsets inside and just past the dead window. The timestamp starts close to its wrap point, so widths are also checked across the modulo boundary.

// File: rtl/tot_pkg.sv
package tot_pkg;
   localparam int RNG_W     = 2;
   localparam int MAX_GAINS = 4;

   typedef enum logic [RNG_W-1:0] {
      RNG_X49 = 2'd0,
      RNG_X7  = 2'd1,
      RNG_X1  = 2'd2
   } range_e;
endpackage

// File: rtl/tot_range_sel.sv
module tot_range_sel
   import tot_pkg::*;
#(
   parameter int NG = 3,
   parameter int WW = 16
) (
   input  logic [WW-1:0]    wid [NG],
   input  logic [NG-1:0]    seen,
   input  logic [WW-1:0]    sat_limit,
   output logic [RNG_W-1:0] rng,
   output logic [WW-1:0]    width
);
   always_comb begin
      rng   = RNG_W'(NG-1);
      width = wid[NG-1];
      for (int g = NG-1; g >= 0; g--) begin
         if (seen[g] && (wid[g] < sat_limit)) begin
            rng   = RNG_W'(g);
            width = wid[g];
         end
      end
   end
endmodule

// File: rtl/tot_chan.sv
module tot_chan
   import tot_pkg::*;
#(
   parameter int NG       = 3,
   parameter int TW       = 32,
   parameter int WW       = 16,
   parameter int DEAD_CYC = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NG-1:0]    lvl,
   input  logic [TW-1:0]    tdc_time,
   input  logic [WW-1:0]    sat_limit,
   input  logic             take,
   output logic             pend_v,
   output logic [RNG_W-1:0] pend_rng,
   output logic [TW-1:0]    pend_time,
   output logic [WW-1:0]    pend_width,
   output logic             reject
);
   localparam int            DW   = $clog2(DEAD_CYC + 1);
   localparam logic [TW-1:0] WMAX = {{(TW-WW){1'b0}}, {WW{1'b1}}};

   if (DEAD_CYC < 2) begin : g_bad_dead
      $error("tot_chan: DEAD_CYC must be at least 2");
   end
   if (WW >= TW) begin : g_bad_width
      $error("tot_chan: WW must be narrower than TW");
   end

   logic [NG-1:0]    lvl_q, seen_q, fell;
   logic [TW-1:0]    lead_q;
   logic [TW-1:0]    fall_q [NG];
   logic             open_q;
   logic [DW-1:0]    dead_q;
   logic             rise, close, accept;
   logic [WW-1:0]    wid [NG];
   logic [RNG_W-1:0] sel_rng;
   logic [WW-1:0]    sel_width;

   assign rise   = (|lvl) & ~(|lvl_q);
   assign close  = open_q & ~(|lvl);
   assign accept = rise & (dead_q == '0) & ~pend_v;
   assign reject = rise & ~accept;
   assign fell   = lvl_q & ~lvl;

   always_comb begin
      for (int g = 0; g < NG; g++) begin
         logic [TW-1:0] stop_t;
         logic [TW-1:0] diff;
         stop_t = fell[g] ? tdc_time : fall_q[g];
         diff   = stop_t - lead_q;
         if (!seen_q[g])
            wid[g] = '0;
         else if (diff > WMAX)
            wid[g] = {WW{1'b1}};
         else
            wid[g] = diff[WW-1:0];
      end
   end

   tot_range_sel #(
      .NG (NG),
      .WW (WW)
   ) i_sel (
      .wid       (wid),
      .seen      (seen_q),
      .sat_limit (sat_limit),
      .rng       (sel_rng),
      .width     (sel_width)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q      <= '0;
         seen_q     <= '0;
         lead_q     <= '0;
         open_q     <= 1'b0;
         dead_q     <= '0;
         pend_v     <= 1'b0;
         pend_rng   <= '0;
         pend_time  <= '0;
         pend_width <= '0;
         for (int g = 0; g < NG; g++) fall_q[g] <= '0;
      end else begin
         lvl_q <= lvl;
         if (accept) begin
            open_q <= 1'b1;
            lead_q <= tdc_time;
            seen_q <= lvl;
            dead_q <= DW'(DEAD_CYC - 1);
         end else if (dead_q != '0) begin
            dead_q <= dead_q - 1'b1;
         end
         if (open_q) begin
            seen_q <= seen_q | lvl;
            for (int g = 0; g < NG; g++) begin
               if (fell[g]) fall_q[g] <= tdc_time;
            end
         end
         if (take) pend_v <= 1'b0;
         if (close) begin
            open_q     <= 1'b0;
            pend_v     <= 1'b1;
            pend_rng   <= sel_rng;
            pend_time  <= lead_q;
            pend_width <= sel_width;
         end
      end
   end

   // R6: a hit never opens while the channel still holds a record
   a_r6_no_open_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_q && pend_v));

   // R5: while the dead counter runs, no hit opens on the next edge
   a_r5_dead_blocks_open: assert property (@(posedge clk) disable iff (!rst_n)
      (dead_q != '0) |=> !$rose(open_q));

   // R1: the start time stays fixed while the hit is open
   a_r1_lead_held: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && $past(open_q)) |-> $stable(lead_q));
endmodule

// File: rtl/tot_arb.sv
module tot_arb #(
   parameter int N      = 3,
   parameter int CHW    = 2,
   parameter bit ARB_RR = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   req,
   input  logic           load,
   output logic [CHW-1:0] gnt_idx,
   output logic           gnt_any
);
   assign gnt_any = |req;

   if (ARB_RR) begin : g_rr
      logic [CHW-1:0] last_q;

      always_comb begin
         logic found;
         found   = 1'b0;
         gnt_idx = '0;
         for (int k = 1; k <= N; k++) begin
            int i;
            i = (int'(last_q) + k) % N;
            if (!found && req[i]) begin
               found   = 1'b1;
               gnt_idx = CHW'(i);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) last_q <= CHW'(N-1);
         else if (load) last_q <= gnt_idx;
      end
   end else begin : g_fixed
      always_comb begin
         gnt_idx = '0;
         for (int i = N-1; i >= 0; i--) begin
            if (req[i]) gnt_idx = CHW'(i);
         end
      end
   end
endmodule

// File: rtl/tot_hit_capture.sv
module tot_hit_capture
   import tot_pkg::*;
#(
   parameter int NCH      = 3,
   parameter int NG       = 3,
   parameter int CHW      = 2,
   parameter int TW       = 32,
   parameter int WW       = 16,
   parameter int DEAD_CYC = 36,
   parameter int LOSS_W   = 8,
   parameter bit ARB_RR   = 1'b1,
   localparam int REC_W   = CHW + RNG_W + TW + WW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*NG-1:0] qtc_lvl,
   input  logic [TW-1:0]     tdc_time,
   input  logic [WW-1:0]     sat_limit,
   input  logic              hit_ready,
   output logic              hit_valid,
   output logic [REC_W-1:0]  hit_rec,
   output logic [LOSS_W-1:0] loss_cnt
);
   localparam int LMAX = (1 << LOSS_W) - 1;
   localparam int NPAD = 1 << CHW;

   if (NG < 1 || NG > MAX_GAINS) begin : g_bad_ng
      $error("tot_hit_capture: NG out of range");
   end
   if (NCH < 1 || NCH > NPAD) begin : g_bad_nch
      $error("tot_hit_capture: NCH does not fit in CHW bits");
   end
   if (LOSS_W < 1 || LOSS_W > 30) begin : g_bad_loss
      $error("tot_hit_capture: LOSS_W out of range");
   end

   logic [NCH-1:0]   pend_v, take, rej;
   logic [RNG_W-1:0] c_rng   [NCH];
   logic [TW-1:0]    c_time  [NCH];
   logic [WW-1:0]    c_width [NCH];
   logic [CHW-1:0]   gnt_idx, cur_q;
   logic             gnt_any, cur_v_q, load;
   logic [NPAD-1:0]  pend_pad;
   logic [LOSS_W-1:0] loss_q, loss_nx;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign take[c] = cur_v_q & hit_ready & (cur_q == CHW'(c));

      tot_chan #(
         .NG       (NG),
         .TW       (TW),
         .WW       (WW),
         .DEAD_CYC (DEAD_CYC)
      ) i_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .lvl        (qtc_lvl[c*NG +: NG]),
         .tdc_time   (tdc_time),
         .sat_limit  (sat_limit),
         .take       (take[c]),
         .pend_v     (pend_v[c]),
         .pend_rng   (c_rng[c]),
         .pend_time  (c_time[c]),
         .pend_width (c_width[c]),
         .reject     (rej[c])
      );
   end

   tot_arb #(
      .N      (NCH),
      .CHW    (CHW),
      .ARB_RR (ARB_RR)
   ) i_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (pend_v),
      .load    (load),
      .gnt_idx (gnt_idx),
      .gnt_any (gnt_any)
   );

   assign load = ~cur_v_q & gnt_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_v_q <= 1'b0;
         cur_q   <= '0;
      end else if (load) begin
         cur_v_q <= 1'b1;
         cur_q   <= gnt_idx;
      end else if (cur_v_q && hit_ready) begin
         cur_v_q <= 1'b0;
      end
   end

   always_comb begin
      hit_rec = '0;
      for (int c = 0; c < NCH; c++) begin
         if (cur_q == CHW'(c))
            hit_rec = {CHW'(c), c_rng[c], c_time[c], c_width[c]};
      end
   end
   assign hit_valid = cur_v_q;

   always_comb begin
      int nrej;
      int tot;
      nrej = 0;
      for (int c = 0; c < NCH; c++) begin
         if (rej[c]) nrej++;
      end
      tot     = int'(loss_q) + nrej;
      loss_nx = (tot > LMAX) ? LOSS_W'(LMAX) : LOSS_W'(tot);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) loss_q <= '0;
      else        loss_q <= loss_nx;
   end
   assign loss_cnt = loss_q;

   always_comb begin
      pend_pad          = '0;
      pend_pad[NCH-1:0] = pend_v;
   end

   // R8: a stalled record is held unchanged
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_rec)));

   // R7: the loss counter never steps back
   a_r7_loss_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      loss_cnt >= $past(loss_cnt));

   // R4: the range field carries only defined gain codes
   a_r4_range_code: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (hit_rec[TW+WW +: RNG_W] != 2'd3));

   // R3: the presented channel still holds its record
   a_r3_grant_has_record: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> pend_pad[cur_q]);
endmodule

// File: tb/test_tot_hit_capture.sv
`timescale 1ns/1ps
module test_tot_hit_capture;
   localparam int NCH  = 3;
   localparam int NG   = 3;
   localparam int DEAD = 36;
   localparam int LW   = 4;
   localparam int LSAT = (1 << LW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*NG-1:0] qtc_lvl = '0;
   logic [31:0]       tdc_time = 32'hFFFF_FFF0;
   logic [15:0]       sat_limit = 16'd30;
   logic              hit_ready = 1'b0;
   logic              hit_valid;
   logic [51:0]       hit_rec;
   logic [LW-1:0]     loss_cnt;

   always #2.5 clk = ~clk;

   tot_hit_capture #(.LOSS_W(LW)) i_tot_hit_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .qtc_lvl   (qtc_lvl),
      .tdc_time  (tdc_time),
      .sat_limit (sat_limit),
      .hit_ready (hit_ready),
      .hit_valid (hit_valid),
      .hit_rec   (hit_rec),
      .loss_cnt  (loss_cnt)
   );

   int n_chk = 0;
   int n_fail = 0;
   int ready_mode = 0;
   bit chk_on = 1'b0;

   task automatic check(bit ok, string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", what);
      end
   endtask

   always @(negedge clk) tdc_time <= tdc_time + 32'd1;

   // reference model state
   bit [NG-1:0] m_prev [NCH];
   bit          m_open [NCH];
   bit [31:0]   m_lead [NCH];
   bit [NG-1:0] m_seen [NCH];
   bit [31:0]   m_fall [NCH][NG];
   int          m_dead [NCH];
   bit          m_pend [NCH];
   int          m_loss;
   bit [51:0]   q [NCH][$];
   bit          hs_flag;
   int          hs_ch;

   function automatic bit [15:0] wcalc(bit s, bit [31:0] f, bit [31:0] l);
      bit [31:0] d;
      d = f - l;
      if (!s) return 16'd0;
      if (d > 32'd65535) return 16'hFFFF;
      return d[15:0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_prev[c] = '0; m_open[c] = 0; m_seen[c] = '0;
            m_dead[c] = 0; m_pend[c] = 0; m_lead[c] = '0;
         end
         m_loss = 0;
         hs_flag = 0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            bit [NG-1:0] now;
            now = qtc_lvl[c*NG +: NG];
            if ((|now) && !(|m_prev[c])) begin
               if (m_dead[c] == 0 && !m_pend[c]) begin
                  m_open[c] = 1; m_lead[c] = tdc_time;
                  m_seen[c] = now; m_dead[c] = DEAD - 1;
               end else begin
                  if (m_loss < LSAT) m_loss++;
                  if (m_dead[c] > 0) m_dead[c]--;
               end
            end else begin
               if (m_dead[c] > 0) m_dead[c]--;
               if (m_open[c]) begin
                  for (int g = 0; g < NG; g++)
                     if (m_prev[c][g] && !now[g]) m_fall[c][g] = tdc_time;
                  m_seen[c] = m_seen[c] | now;
                  if (!(|now)) begin
                     bit [15:0] wd [NG];
                     bit [1:0]  rg;
                     bit [15:0] wsel;
                     for (int g = 0; g < NG; g++)
                        wd[g] = wcalc(m_seen[c][g], m_fall[c][g], m_lead[c]);
                     rg = 2'd2; wsel = wd[2];
                     for (int g = NG-1; g >= 0; g--)
                        if (m_seen[c][g] && wd[g] < sat_limit) begin
                           rg = 2'(g); wsel = wd[g];
                        end
                     q[c].push_back({2'(c), rg, m_lead[c], wsel});
                     m_pend[c] = 1; m_open[c] = 0;
                  end
               end
            end
            m_prev[c] = now;
         end
         if (hs_flag) begin
            m_pend[hs_ch] = 0;
            hs_flag = 0;
         end
      end
   end

   // per-cycle comparison, away from the rising edge
   bit        pv, pr;
   bit [51:0] prec;
   always @(negedge clk) begin
      if (chk_on) begin
         check(int'(loss_cnt) == m_loss,
               $sformatf("R7 loss count got %0d expected %0d", loss_cnt, m_loss));
         if (pv && !pr)
            check(hit_valid && hit_rec == prec,
                  $sformatf("R8 stalled record got v=%0b %h expected v=1 %h", hit_valid, hit_rec, prec));
         case (ready_mode)
            0:       hit_ready = 1'b1;
            1:       hit_ready = 1'($urandom % 2);
            default: hit_ready = 1'b0;
         endcase
         if (hit_valid && hit_ready) begin
            int ch;
            ch = int'(hit_rec[51:50]);
            if (ch >= NCH) begin
               check(1'b0, $sformatf("R3 record channel got %0d expected below %0d", ch, NCH));
            end else begin
               if (q[ch].size() == 0) begin
                  check(1'b0, $sformatf("R3 unexpected record got %h expected none", hit_rec));
               end else begin
                  bit [51:0] exp;
                  exp = q[ch].pop_front();
                  check(hit_rec == exp,
                        $sformatf("R1 R2 R4 ch%0d record got %h expected %h", ch, hit_rec, exp));
               end
               hs_flag = 1; hs_ch = ch;
            end
         end
      end
      pv = hit_valid; pr = hit_ready; prec = hit_rec;
   end

   task automatic hit(int ch, int w0, int w1, int w2);
      int w [3];
      int mx;
      w[0] = w0; w[1] = w1; w[2] = w2;
      mx = w0;
      if (w1 > mx) mx = w1;
      if (w2 > mx) mx = w2;
      @(negedge clk);
      for (int g = 0; g < NG; g++) if (w[g] > 0) qtc_lvl[ch*NG + g] = 1'b1;
      for (int k = 1; k <= mx; k++) begin
         @(negedge clk);
         for (int g = 0; g < NG; g++) if (w[g] == k) qtc_lvl[ch*NG + g] = 1'b0;
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rand_ch(int ch);
      for (int it = 0; it < 25; it++) begin
         hit(ch, 1 + int'($urandom % 60), int'($urandom % 61), int'($urandom % 61));
         idle(1 + int'($urandom % 50));
      end
   endtask

   task automatic body();
      idle(4);
      check(hit_valid == 1'b0, $sformatf("R9 valid after reset got %0b expected 0", hit_valid));
      check(loss_cnt == '0, $sformatf("R9 loss after reset got %0d expected 0", loss_cnt));
      rst_n = 1'b1;
      chk_on = 1'b1;
      ready_mode = 0;
      // R1 R2 R4: gain selection patterns, first crosses the timestamp wrap
      hit(0, 5, 20, 40);  idle(40);
      hit(1, 40, 20, 5);  idle(40);
      hit(2, 40, 35, 33); idle(40);
      hit(0, 0, 10, 12);  idle(40);
      // R5: start at offset 35 is lost, at offset 36 is taken
      hit(1, 3, 3, 3); idle(31); hit(1, 2, 2, 2); idle(40);
      hit(1, 3, 3, 3); idle(32); hit(1, 2, 2, 2); idle(40);
      // R10: another channel starts inside a dead window
      fork
         hit(1, 3, 3, 3);
         begin idle(5); hit(2, 4, 4, 4); end
      join
      idle(40);
      // R6: record not taken, next start is lost
      ready_mode = 2;
      hit(0, 6, 6, 6); idle(40); hit(0, 6, 6, 6); idle(10);
      ready_mode = 0;
      idle(20);
      // R7: drive the loss counter into saturation
      for (int r = 0; r < 2; r++) begin
         hit(2, 1, 1, 1);
         repeat (15) hit(2, 1, 0, 0);
         idle(40);
      end
      // R2: width clamp on a very long pulse
      sat_limit = 16'hFFFF;
      hit(0, 70000, 70000, 70000); idle(10);
      sat_limit = 16'd30;
      // R8 R10: concurrent random traffic with random backpressure
      ready_mode = 1;
      fork
         rand_ch(0);
         rand_ch(1);
         rand_ch(2);
      join
      ready_mode = 0;
      idle(200);
      for (int c = 0; c < NCH; c++)
         check(q[c].size() == 0,
               $sformatf("R3 ch%0d undelivered records got %0d expected 0", c, q[c].size()));
   endtask

   initial begin
      fork
         body();
         begin
            idle(190000);
            n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule